// File: doc/BRIEF.md
# Multi-Level Aging Page Tracker

This block tracks how recently each resident page frame in the top level of a three-level memory hierarchy has been used. Examples of such a hierarchy are DRAM over storage-class memory over disk. Each frame has an age counter and a reference flag. A reference strobe sets the flag. A periodic tick, which belongs to this level alone, shifts every counter one place toward its low end and moves the flag into the top bit. Recently used frames therefore carry large counter values. Frames left idle decay toward zero.

When a victim is needed, a scanner state machine reads one frame per cycle. It returns the frame with the smallest counter, together with a destination level for that frame. The destination comes from the number of leading zeros in the victim's counter. A page that still shows fairly recent use goes one level down. A page that has sat idle for at least half the counter history goes to the deepest level. After the data has moved, a load strobe for the same index zeroes the counter for the incoming page. Page contents, page tables and the lower levels' replacement are handled elsewhere.

The scanner has three states. In SC_IDLE it waits for a request, and a request takes it to SC_SCAN. In SC_SCAN it visits frames 0 to N-1 in turn, and after the last frame it moves to SC_DONE. SC_DONE lasts one cycle and raises the done output. From SC_DONE it returns to SC_SCAN if a request is held or newly present, and to SC_IDLE otherwise.

Top module: `page_age_tracker`

## Requirements
- R1: After reset, every counter and every reference flag is zero, the done output is low and the scanner is idle. A first victim request therefore returns frame 0 with level 3.
- R2: A counter changes only on a tick or on a load strobe for its frame. Reference strobes on their own leave every counter as it was.
- R3: On a tick, each counter shifts right by one place. Its frame's reference flag enters the top bit, and the flag is then cleared, so a frame not referenced again ages in a zero on the next tick.
- R4: A reference strobe in the same cycle as a tick is included in that tick, so its frame's counter gets a 1 in the top bit.
- R5: A victim request accepted while the scanner is idle produces a done pulse exactly one cycle long. The pulse is seen N+1 cycles after the request cycle.
- R6: The victim is the frame with the smallest counter value. When several frames tie, the lowest index wins.
- R7: The level is encoded as 2 for the next level down and 3 for the deepest level. With AGE_W-bit counters, a leading-zero count below AGE_W/2 gives 2. A count of AGE_W/2 or more gives 3, and this includes an all-zero counter.
- R8: A load strobe zeroes its frame's counter and clears its reference flag. It takes precedence over a tick or a reference strobe on the same frame in the same cycle.
- R9: A victim request that arrives while a scan is in progress is held. A second full scan runs after the current one finishes and gives a second done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Reference strobe |
| ref_frame | input | IDX_W | Frame index referenced |
| tick | input | 1 | Aging tick for this level |
| load_valid | input | 1 | New-page load strobe |
| load_frame | input | IDX_W | Frame index being loaded |
| vic_req | input | 1 | Victim request |
| vic_done | output | 1 | One-cycle pulse: victim result valid |
| vic_frame | output | IDX_W | Victim frame index |
| vic_level | output | 2 | Destination level, 2 or 3 |

## Verification
The bench targets these corner cases:

- Ties: it gives all counters an equal value. A design that broke ties by the last index scanned would name the wrong frame.
- Same-cycle reference and tick: it places a reference strobe exactly on a tick. A design that dropped that reference would return that frame as the victim with level 3.
- Stale reference flag: it ticks twice with no reference in between. A design that kept the flag set would produce a tie and change the victim.
- Level threshold: it builds counters with three and with four leading zeros, which exposes an off-by-one in the threshold.
- Load precedence: it applies a load, a tick and a reference to one frame in the same cycle. A design that let the reference survive would report level 2 for that frame instead of 3.
- Held request: it issues a request in the middle of a scan. A design that discarded it would give only one done pulse.

// File: rtl/page_age_pkg.sv
package page_age_pkg;
    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_SCAN = 2'd1,
        SC_DONE = 2'd2
    } scan_state_e;

    localparam logic [1:0] LEVEL_MID  = 2'd2;
    localparam logic [1:0] LEVEL_DEEP = 2'd3;
endpackage

// File: rtl/age_bank.sv
module age_bank #(
    parameter int N_FRAMES = 8,
    parameter int AGE_W    = 8,
    localparam int IDX_W   = $clog2(N_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_frame,
    input  logic             load_valid,
    input  logic [IDX_W-1:0] load_frame,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [AGE_W-1:0] rd_age
);
    logic [N_FRAMES-1:0][AGE_W-1:0] age_q;
    logic [N_FRAMES-1:0]            ref_q;

    for (genvar f = 0; f < N_FRAMES; f++) begin : g_frame
        logic hit_ref;
        logic hit_load;
        assign hit_ref  = ref_valid  && (ref_frame  == IDX_W'(f));
        assign hit_load = load_valid && (load_frame == IDX_W'(f));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age_q[f] <= '0;
                ref_q[f] <= 1'b0;
            end else if (hit_load) begin
                age_q[f] <= '0;
                ref_q[f] <= 1'b0;
            end else if (tick) begin
                age_q[f] <= {ref_q[f] | hit_ref, age_q[f][AGE_W-1:1]};
                ref_q[f] <= 1'b0;
            end else if (hit_ref) begin
                ref_q[f] <= 1'b1;
            end
        end
    end

    assign rd_age = age_q[rd_idx];

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_valid) |=> $stable(age_q));

    p_tick_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(load_valid && load_frame == ref_frame))
        |=> age_q[$past(ref_frame)][AGE_W-2:0] == $past(age_q[ref_frame][AGE_W-1:1]));

    p_ref_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ref_valid) |=> ref_q == '0);

    p_same_cycle_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ref_valid && !(load_valid && load_frame == ref_frame))
        |=> age_q[$past(ref_frame)][AGE_W-1]);

    p_load_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> (age_q[$past(load_frame)] == '0 && !ref_q[$past(load_frame)]));
endmodule

// File: rtl/lz_level.sv
module lz_level
    import page_age_pkg::*;
#(
    parameter int AGE_W = 8
) (
    input  logic [AGE_W-1:0] age,
    output logic [1:0]       level
);
    localparam int HALF = AGE_W / 2;

    int  lz;
    logic seen;

    always_comb begin
        lz   = 0;
        seen = 1'b0;
        for (int i = AGE_W - 1; i >= 0; i--) begin
            if (age[i]) seen = 1'b1;
            else if (!seen) lz = lz + 1;
        end
        level = (lz < HALF) ? LEVEL_MID : LEVEL_DEEP;
    end
endmodule

// File: rtl/victim_scanner.sv
module victim_scanner
    import page_age_pkg::*;
#(
    parameter int N_FRAMES = 8,
    parameter int AGE_W    = 8,
    localparam int IDX_W   = $clog2(N_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vic_req,
    input  logic [AGE_W-1:0] rd_age,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] best_idx,
    output logic [AGE_W-1:0] best_age,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_FRAMES - 1);

    scan_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             pending_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE: if (vic_req) state_d = SC_SCAN;
            SC_SCAN: if (idx_q == LAST) state_d = SC_DONE;
            SC_DONE: state_d = (pending_q || vic_req) ? SC_SCAN : SC_IDLE;
            default: state_d = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            pending_q <= 1'b0;
            best_idx  <= '0;
            best_age  <= '0;
        end else begin
            if (state_q == SC_DONE)
                pending_q <= 1'b0;
            else if (vic_req && state_q != SC_IDLE)
                pending_q <= 1'b1;

            if (state_q == SC_SCAN) begin
                if (idx_q == '0 || rd_age < best_age) begin
                    best_age <= rd_age;
                    best_idx <= idx_q;
                end
                idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
            end else begin
                idx_q <= '0;
            end
        end
    end

    always_comb begin
        rd_idx = idx_q;
        done   = (state_q == SC_DONE);
    end

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_SCAN) |-> (rd_idx <= LAST));

    p_best_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_SCAN && rd_idx != '0) |=> best_age <= $past(rd_age));

    p_pending_served_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pending_q) |=> state_q == SC_SCAN);
endmodule

// File: rtl/page_age_tracker.sv
module page_age_tracker
    import page_age_pkg::*;
#(
    parameter int N_FRAMES = 8,
    parameter int AGE_W    = 8,
    localparam int IDX_W   = $clog2(N_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_frame,
    input  logic             tick,
    input  logic             load_valid,
    input  logic [IDX_W-1:0] load_frame,
    input  logic             vic_req,
    output logic             vic_done,
    output logic [IDX_W-1:0] vic_frame,
    output logic [1:0]       vic_level
);
    logic [IDX_W-1:0] rd_idx;
    logic [AGE_W-1:0] rd_age;
    logic [AGE_W-1:0] best_age;

    age_bank #(.N_FRAMES(N_FRAMES), .AGE_W(AGE_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .ref_valid  (ref_valid),
        .ref_frame  (ref_frame),
        .load_valid (load_valid),
        .load_frame (load_frame),
        .rd_idx     (rd_idx),
        .rd_age     (rd_age)
    );

    victim_scanner #(.N_FRAMES(N_FRAMES), .AGE_W(AGE_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .vic_req  (vic_req),
        .rd_age   (rd_age),
        .rd_idx   (rd_idx),
        .best_idx (vic_frame),
        .best_age (best_age),
        .done     (vic_done)
    );

    lz_level #(.AGE_W(AGE_W)) u_level (
        .age   (best_age),
        .level (vic_level)
    );

    p_zero_deep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_done && best_age == '0) |-> vic_level == LEVEL_DEEP);

    p_top_set_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_done && best_age[AGE_W-1]) |-> vic_level == LEVEL_MID);
endmodule

// File: tb/page_age_tracker_test.sv
module page_age_tracker_test;
    localparam int N = 8;
    localparam int W = 8;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_valid = 1'b0, tick = 1'b0, load_valid = 1'b0, vic_req = 1'b0;
    logic [IW-1:0] ref_frame = '0, load_frame = '0;
    logic vic_done;
    logic [IW-1:0] vic_frame;
    logic [1:0] vic_level;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [W-1:0] m_age [N];
    bit m_ref [N];

    always #4 clk = ~clk;

    page_age_tracker #(.N_FRAMES(N), .AGE_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
        .tick(tick), .load_valid(load_valid), .load_frame(load_frame),
        .vic_req(vic_req), .vic_done(vic_done), .vic_frame(vic_frame),
        .vic_level(vic_level));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ref_valid = 0; tick = 0; load_valid = 0; vic_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin m_age[i] = '0; m_ref[i] = 0; end
    endtask

    // one-cycle strobe; any combination of reference, tick and load
    task automatic step(input bit r, input int rf, input bit t, input bit l, input int lf);
        ref_valid = r; ref_frame = IW'(rf); tick = t; load_valid = l; load_frame = IW'(lf);
        @(negedge clk);
        ref_valid = 0; tick = 0; load_valid = 0;
        for (int i = 0; i < N; i++) begin
            bit hr = r && (i == rf);
            if (l && i == lf) begin m_age[i] = '0; m_ref[i] = 0; end
            else if (t) begin m_age[i] = {m_ref[i] | hr, m_age[i][W-1:1]}; m_ref[i] = 0; end
            else if (hr) m_ref[i] = 1;
        end
    endtask

    task automatic ref_all_but(input int skip);
        for (int i = 0; i < N; i++) if (i != skip) step(1, i, 0, 0, 0);
    endtask

    function automatic int exp_victim();
        int b = 0;
        for (int i = 1; i < N; i++) if (m_age[i] < m_age[b]) b = i;
        return b;
    endfunction

    function automatic int exp_level(input logic [W-1:0] a);
        int lz = 0;
        for (int i = W - 1; i >= 0; i--) begin if (a[i]) break; lz++; end
        return (lz < W / 2) ? 2 : 3;
    endfunction

    task automatic victim(input string req);
        int cyc, v;
        vic_req = 1; @(negedge clk); vic_req = 0;
        cyc = 1;
        while (!vic_done && cyc < 100) begin @(negedge clk); cyc++; end
        v = exp_victim();
        check({req, " latency"}, cyc, N + 1);
        check({req, " frame"}, int'(vic_frame), v);
        check({req, " level"}, int'(vic_level), exp_level(m_age[v]));
        @(negedge clk);
        check("R5 done one cycle", int'(vic_done), 0);
    endtask

    task automatic t_reset_r1();
        do_reset();
        check("R1 done low after reset", int'(vic_done), 0);
        victim("R1 reset victim");
    endtask

    task automatic t_ref_only_r2();
        do_reset();
        step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 1, 0, 0, 0);
        victim("R2 refs without tick");
    endtask

    task automatic t_tie_r6();
        do_reset();
        step(1, 0, 1, 0, 0);
        victim("R6 tie lowest index");
        do_reset();
        ref_all_but(5); step(0, 0, 1, 0, 0);
        victim("R6 smallest counter");
    endtask

    task automatic t_ref_clear_r3();
        do_reset();
        ref_all_but(-1); step(0, 0, 1, 0, 0);
        ref_all_but(2); step(0, 0, 1, 0, 0);
        victim("R3 flag cleared after tick");
    endtask

    task automatic t_same_cycle_r4();
        do_reset();
        ref_all_but(3); step(1, 3, 1, 0, 0);
        victim("R4 ref on tick");
    endtask

    task automatic t_threshold_r7(input int idle_ticks);
        do_reset();
        ref_all_but(-1); step(0, 0, 1, 0, 0);
        for (int k = 0; k < idle_ticks; k++) begin ref_all_but(6); step(0, 0, 1, 0, 0); end
        victim(idle_ticks == 3 ? "R7 three leading zeros" : "R7 four leading zeros");
    endtask

    task automatic t_load_r8();
        do_reset();
        ref_all_but(-1); step(0, 0, 1, 0, 0);
        ref_all_but(6); step(1, 6, 1, 1, 6);
        ref_all_but(6); step(0, 0, 1, 0, 0);
        victim("R8 load wins over tick and ref");
        ref_all_but(6); step(1, 6, 1, 0, 0);
        step(0, 0, 0, 1, 6);
        victim("R8 load alone zeroes");
    endtask

    task automatic t_held_r9();
        int pulses = 0, v;
        do_reset();
        ref_all_but(4); step(0, 0, 1, 0, 0);
        v = exp_victim();
        vic_req = 1; @(negedge clk); vic_req = 0;
        repeat (3) @(negedge clk);
        vic_req = 1; @(negedge clk); vic_req = 0;
        for (int c = 0; c < 40; c++) begin
            if (vic_done) begin
                pulses++;
                check("R9 held request frame", int'(vic_frame), v);
            end
            @(negedge clk);
        end
        check("R9 two done pulses", pulses, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_r1();
        t_ref_only_r2();
        t_tie_r6();
        t_ref_clear_r3();
        t_same_cycle_r4();
        t_threshold_r7(3);
        t_threshold_r7(4);
        t_load_r8();
        t_held_r9();
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule